// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block puts one packet onto a low-speed USB pair. When it receives a start pulse, it takes the bus. It first drives the idle (J) level with its drivers still off, and only then turns the drivers on. It sends a fixed sync byte and then a programmable number of payload bytes, least-significant bit first. The line coding is NRZI, and a stuffed bit follows every run of six ones. The packet ends with a two-bit single-ended zero, then one bit of J, and then the drivers are released. A one-clock done pulse marks the release.

Payload bytes come from an external source through a simple request handshake. The block asks for the next byte while it is still sending the last bit of the current one, so bytes follow each other on the wire with no gap. A handshake packet is simply a one-byte payload that carries the PID. The block does not form CRC or any other packet content.

Top module: `usb_ls_tx`

## Requirements
- R1: While reset is active and while the block is idle, `oe_o`, `dp_o`, `dm_o`, `done_o` and `byte_req_o` are all 0.
- R2: A `start_i` pulse seen while idle starts the packet. For one bit time the lines show J (`dp_o`=0, `dm_o`=1) with `oe_o`=0. `oe_o` rises only after that.
- R3: Every line symbol lasts exactly `BIT_CLKS` clocks. `oe_o` rises `BIT_CLKS` clocks after the edge that accepted `start_i`.
- R4: The first eight symbols carry the sync byte 0x80, sent bit 0 first, so there are seven zeros followed by a one.
- R5: NRZI coding: starting from J, a data 0 flips the lines between J (01) and K (`dp_o`=1, `dm_o`=0), and a data 1 keeps the lines where they are. The payload bytes are sent LSB first, in order.
- R6: After six consecutive data ones, one extra symbol that flips the lines is inserted. The run count starts at the sync byte, carries across byte boundaries, and also applies after the last payload bit.
- R7: After the final bit (and any stuffed bit), the block drives `dp_o`=`dm_o`=0 for two bit times, then J for one bit time, then drops `oe_o`.
- R8: `done_o` is high for exactly one clock, on the clock in which `oe_o` first reads 0 after a packet.
- R9: `byte_req_o` pulses for one clock each time the last bit of a byte begins and more payload remains. This gives exactly `nbytes_i` pulses per packet. The source updates `byte_i` at the rising edge where it sees `byte_req_o` high, and the block samples it at the following edge.
- R10: `start_i` and `nbytes_i` are ignored while a packet is in progress, and no second packet follows.
- R11: With `nbytes_i` = 0, only the sync byte is sent, followed by the end-of-packet sequence, and no byte is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| nbytes_i | input | CNT_W | Payload byte count, latched at start |
| byte_req_o | output | 1 | One-clock request for the next payload byte |
| byte_i | input | 8 | Payload byte from the source |
| dp_o | output | 1 | D+ drive value |
| dm_o | output | 1 | D− drive value |
| oe_o | output | 1 | Driver enable for both lines |
| done_o | output | 1 | One-clock pulse when the bus is released |

## Verification
The bench goes after stuffing at the awkward places:
- a run of ones that starts in the sync byte;
- a run that crosses from one payload byte into the next;
- a run of six that ends exactly on the last payload bit.

A design that reset its run count per byte, or that skipped the stuffed bit before end-of-packet, would show a missing K/J flip at that symbol. Sync-only packets and single-byte packets check the fetch timing: a request issued late, or one request too many, would change the line symbols or the request count. A start pulse in the middle of a packet checks that the block does not restart and does not chain a second packet. Slot-by-slot comparison of the lines catches off-by-one end-of-packet lengths, a done pulse on the wrong clock, and drivers enabled before the idle level.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_PRE,
    TX_DATA,
    TX_SE0,
    TX_TAIL
  } tx_state_e;

  localparam logic [7:0] SYNC_PATTERN = 8'h80;
  localparam int         STUFF_LIMIT  = 6;

endpackage

// File: rtl/usb_ls_tx_baud.sv
module usb_ls_tx_baud #(
  parameter int BIT_CLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(BIT_CLKS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en)
      cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/usb_ls_tx_stuff.sv
module usb_ls_tx_stuff #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_done,
  input  logic bit_val,
  output logic need_stuff
);
  localparam int RW = $clog2(RUN + 1);

  logic [RW-1:0] run_q, run_d;

  assign need_stuff = bit_done && bit_val && (run_q == RW'(RUN - 1));

  always_comb begin
    run_d = run_q;
    if (clr)
      run_d = '0;
    else if (bit_done)
      run_d = (!bit_val || need_stuff) ? '0 : run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/usb_ls_tx_line.sv
module usb_ls_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic set_j,
  input  logic toggle,
  output logic lvl_j
);
  logic lvl_d;

  always_comb begin
    lvl_d = lvl_j;
    if (set_j)       lvl_d = 1'b1;
    else if (toggle) lvl_d = ~lvl_j;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_j <= 1'b1;
    else        lvl_j <= lvl_d;
  end
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int BIT_CLKS = 32,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbytes_i,
  output logic             byte_req_o,
  input  logic [7:0]       byte_i,
  output logic             dp_o,
  output logic             dm_o,
  output logic             oe_o,
  output logic             done_o
);
  localparam logic [2:0] LAST_BIT = 3'd7;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  tx_state_e        state_q, state_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [2:0]       bidx_q, bidx_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [7:0]       nxt_q, nxt_d;
  logic             req_q, req_d;
  logic             fetch_q;
  logic             stuff_q, stuff_d;
  logic             ph_q, ph_d;
  logic             done_q, done_d;

  logic tick_w, need_stuff, bit_done, set_j, toggle, lvl_j, start_ok;

  assign start_ok = (state_q == TX_IDLE) && start_i;

  usb_ls_tx_baud #(.BIT_CLKS(BIT_CLKS)) baud_i (
    .clk  (clk),
    .rst_n(rst_ns),
    .clr  (start_ok),
    .en   (state_q != TX_IDLE),
    .tick (tick_w)
  );

  usb_ls_tx_stuff #(.RUN(STUFF_LIMIT)) stuff_i (
    .clk       (clk),
    .rst_n     (rst_ns),
    .clr       (start_ok),
    .bit_done  (bit_done),
    .bit_val   (shreg_q[0]),
    .need_stuff(need_stuff)
  );

  usb_ls_tx_line line_i (
    .clk   (clk),
    .rst_n (rst_ns),
    .set_j (set_j),
    .toggle(toggle),
    .lvl_j (lvl_j)
  );

  assign bit_done = (state_q == TX_DATA) && tick_w && !stuff_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    bidx_d  = bidx_q;
    left_d  = left_q;
    stuff_d = stuff_q;
    ph_d    = ph_q;
    req_d   = 1'b0;
    done_d  = 1'b0;
    set_j   = 1'b0;
    toggle  = 1'b0;
    nxt_d   = fetch_q ? byte_i : nxt_q;

    unique case (state_q)
      TX_IDLE: begin
        if (start_i) begin
          state_d = TX_PRE;
          shreg_d = SYNC_PATTERN;
          bidx_d  = '0;
          left_d  = nbytes_i;
          stuff_d = 1'b0;
          set_j   = 1'b1;
        end
      end
      TX_PRE: begin
        if (tick_w) begin
          state_d = TX_DATA;
          toggle  = ~shreg_q[0];
        end
      end
      TX_DATA: begin
        if (tick_w) begin
          if (!stuff_q && need_stuff) begin
            stuff_d = 1'b1;
            toggle  = 1'b1;
          end else begin
            stuff_d = 1'b0;
            if (bidx_q == LAST_BIT) begin
              if (left_q == '0) begin
                state_d = TX_SE0;
                ph_d    = 1'b0;
              end else begin
                shreg_d = nxt_q;
                bidx_d  = '0;
                left_d  = left_q - CNT_W'(1);
                toggle  = ~nxt_q[0];
              end
            end else begin
              shreg_d = {1'b0, shreg_q[7:1]};
              bidx_d  = bidx_q + 3'd1;
              toggle  = ~shreg_q[1];
              if (bidx_q == LAST_BIT - 3'd1 && left_q != '0)
                req_d = 1'b1;
            end
          end
        end
      end
      TX_SE0: begin
        if (tick_w) begin
          if (ph_q) begin
            state_d = TX_TAIL;
            set_j   = 1'b1;
          end else begin
            ph_d = 1'b1;
          end
        end
      end
      TX_TAIL: begin
        if (tick_w) begin
          state_d = TX_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= TX_IDLE;
      shreg_q <= '0;
      bidx_q  <= '0;
      left_q  <= '0;
      nxt_q   <= '0;
      req_q   <= 1'b0;
      fetch_q <= 1'b0;
      stuff_q <= 1'b0;
      ph_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bidx_q  <= bidx_d;
      left_q  <= left_d;
      nxt_q   <= nxt_d;
      req_q   <= req_d;
      fetch_q <= req_q;
      stuff_q <= stuff_d;
      ph_q    <= ph_d;
      done_q  <= done_d;
    end
  end

  // line mapping: J = dp 0 / dm 1, K = dp 1 / dm 0
  always_comb begin
    oe_o = 1'b0;
    dp_o = 1'b0;
    dm_o = 1'b0;
    unique case (state_q)
      TX_PRE:  dm_o = 1'b1;
      TX_DATA: begin
        oe_o = 1'b1;
        dp_o = ~lvl_j;
        dm_o = lvl_j;
      end
      TX_SE0:  oe_o = 1'b1;
      TX_TAIL: begin
        oe_o = 1'b1;
        dm_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign byte_req_o = req_q;
  assign done_o     = done_q;

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic oe_o,
  input logic dp_o,
  input logic dm_o,
  input logic done_o,
  input logic byte_req_o
);
  // R2
  oe_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(dm_o && !dp_o));

  // R5
  no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_o && dm_o));

  // R3
  symbol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && !tick) |=> $stable({oe_o, dp_o, dm_o}));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!oe_o && $past(oe_o)));

  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req_o |=> !byte_req_o);

  // R9
  req_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req_o |-> oe_o);
endmodule

bind usb_ls_tx usb_ls_tx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_ns),
  .tick      (tick_w),
  .oe_o      (oe_o),
  .dp_o      (dp_o),
  .dm_o      (dm_o),
  .done_o    (done_o),
  .byte_req_o(byte_req_o)
);

// File: tb/usb_ls_tx_tb_top.sv
module usb_ls_tx_tb_top;
  localparam int DIV = 8;
  localparam int CW  = 4;

  logic          clk, rst_n, start_i;
  logic [CW-1:0] nbytes_i;
  logic [7:0]    byte_i;
  logic          byte_req_o, dp_o, dm_o, oe_o, done_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [16];
  int         ridx, nreq;
  logic [1:0] exp_ln [256];
  string      exp_tag [256];
  int         nslots;

  usb_ls_tx #(.BIT_CLKS(DIV), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbytes_i(nbytes_i),
    .byte_req_o(byte_req_o), .byte_i(byte_i), .dp_o(dp_o), .dm_o(dm_o),
    .oe_o(oe_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // byte source: answers each request at the edge where it sees it (R9)
  initial begin
    byte_i = 8'h00;
    forever begin
      @(posedge clk);
      if (byte_req_o) begin
        byte_i <= mem[ridx[3:0]];
        ridx++;
        nreq++;
      end
    end
  end

  // expected line symbols, 2'b01 = J, 2'b10 = K, 2'b00 = SE0
  function automatic void build(input int n);
    logic lvl;
    int   run;
    logic [7:0] b;
    lvl = 1'b1; run = 0; nslots = 0;
    for (int k = 0; k <= n; k++) begin
      b = (k == 0) ? 8'h80 : mem[k-1];
      for (int i = 0; i < 8; i++) begin
        if (!b[i]) lvl = ~lvl;
        run = b[i] ? run + 1 : 0;
        exp_ln[nslots] = lvl ? 2'b01 : 2'b10;
        exp_tag[nslots] = (k == 0) ? "R4" : "R5";
        nslots++;
        if (run == 6) begin
          lvl = ~lvl; run = 0;
          exp_ln[nslots] = lvl ? 2'b01 : 2'b10;
          exp_tag[nslots] = "R6";
          nslots++;
        end
      end
    end
    for (int e = 0; e < 3; e++) begin
      exp_ln[nslots] = (e < 2) ? 2'b00 : 2'b01;
      exp_tag[nslots] = "R7";
      nslots++;
    end
  endfunction

  task automatic run_pkt(input int n, input bit inject);
    int c;
    build(n);
    ridx = 0; nreq = 0;
    @(negedge clk); start_i = 1'b1; nbytes_i = CW'(n);
    @(negedge clk); start_i = 1'b0;
    chk("R2", {oe_o, dp_o, dm_o}, 3'b001, "pre-enable idle level");
    c = 1;
    while (!oe_o && c < 1000) begin @(negedge clk); c++; end
    chk("R3", c, DIV + 1, "clocks from start to enable");
    for (int s = 0; s < nslots; s++) begin
      chk(exp_tag[s], {oe_o, dp_o, dm_o}, {1'b1, exp_ln[s]}, $sformatf("slot %0d", s));
      if (inject && s == 5) begin
        start_i = 1'b1; nbytes_i = CW'(3);
        @(negedge clk); start_i = 1'b0;
        repeat (DIV - 1) @(negedge clk);
      end else begin
        repeat (DIV) @(negedge clk);
      end
    end
    chk("R7", oe_o, 0, "enable released after tail");
    chk("R8", done_o, 1, "done at release");
    @(negedge clk);
    chk("R8", done_o, 0, "done one clock");
    chk(n == 0 ? "R11" : "R9", nreq, n, "byte requests");
    if (inject) begin
      repeat (3 * DIV) @(negedge clk);
      chk("R10", {oe_o, dp_o, dm_o}, 0, "no packet from start in flight");
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; start_i = 1'b0; nbytes_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", {oe_o, dp_o, dm_o, done_o, byte_req_o}, 0, "reset outputs");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {oe_o, dp_o, dm_o, done_o, byte_req_o}, 0, "idle outputs");

    run_pkt(0, 1'b0);                                   // R11 sync only
    mem[0] = 8'hD2; run_pkt(1, 1'b0);                   // handshake-sized
    mem[0] = 8'hFF; mem[1] = 8'hFF; run_pkt(2, 1'b0);   // R6 run from sync
    mem[0] = 8'hE0; mem[1] = 8'h07; run_pkt(2, 1'b0);   // R6 across bytes
    mem[0] = 8'hFC; run_pkt(1, 1'b0);                   // R6 before end
    mem[0] = 8'h00; mem[1] = 8'h55; mem[2] = 8'hAA; run_pkt(3, 1'b1); // R10
    for (int p = 0; p < 18; p++) begin
      n = 1 + ($urandom % 15);
      for (int k = 0; k < 16; k++)
        mem[k] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
      run_pkt(n, 1'b0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule